// File: doc/BRIEF.md
# Memoizing Window Edge-Strength Unit

This block puts a reuse layer in front of a multi-cycle edge-strength kernel that works on 3x3 pixel windows. For each window it accepts, the block compares the central pixel against a stored reference pixel. If the two are similar enough, it returns a stored result one cycle later and does not start the kernel. If they are not, it starts the kernel, waits for it to finish and returns the computed value. A hit flag travels with every result, so a consumer can tell a reused value from a computed one.

The block has two operating modes. In the fixed mode, the reference pixel and the reuse value are configuration inputs, which stay constant while traffic flows. This mode suits streams whose central pixel stays near one known level. In the tracking mode, the block keeps its own reference entry. The entry is refilled from every window that actually passes through the kernel, and it starts out empty after reset. This mode suits streams that drift widely over time. Similarity is either exact equality or an absolute difference no larger than a programmed threshold.

Windows arrive over a valid/ready handshake. Results leave as a single-cycle valid pulse together with the data and the hit flag. The block takes no new window while a kernel computation is in flight.

Top module: `memo_wrap`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: The window holds pixel k (k = 3*row + col, row 0 at the top, col 0 at the left) in in_win[8k+7:8k]. The kernel result is |Gx|+|Gy|, saturated at 255. Gx = (p2+2*p5+p8) - (p0+2*p3+p6) and Gy = (p6+2*p7+p8) - (p0+2*p1+p2).
- R3: With cfg_dynamic=0, a window whose centre pixel p4 matches cfg_ref_pix returns cfg_ref_out with out_hit=1. This holds from the first window after reset.
- R4: With cfg_use_dist=0, a match requires p4 to equal the reference exactly, and cfg_thresh has no effect.
- R5: With cfg_use_dist=1, a match holds exactly when |p4 - reference| <= cfg_thresh, computed on unsigned 8-bit values.
- R6: With cfg_dynamic=1, the reference pixel and the reuse value are the centre pixel and the result of the last window that went through the kernel. A later miss replaces both.
- R7: With cfg_dynamic=1, the first window after reset always goes to the kernel (out_hit=0), whatever its centre pixel.
- R8: A hit produces out_valid with out_hit=1 in the cycle after the window is accepted. The kernel is not started for it, and in_ready stays high.
- R9: A miss starts the kernel and drops in_ready from the cycle after acceptance until the result is delivered, at most LATENCY cycles. The result then appears with out_hit=0.
- R10: Results leave in acceptance order, one result per accepted window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Block can take a window |
| in_win | input | 72 | Nine 8-bit pixels, pixel k at bits 8k+7:8k |
| cfg_dynamic | input | 1 | 1 = tracking mode, 0 = fixed mode |
| cfg_use_dist | input | 1 | 1 = distance test, 0 = equality test |
| cfg_thresh | input | 8 | Largest absolute difference counted as a match |
| cfg_ref_pix | input | 8 | Fixed-mode reference centre pixel |
| cfg_ref_out | input | 8 | Fixed-mode reuse value |
| out_valid | output | 1 | Result pulse |
| out_data | output | 8 | Result value |
| out_hit | output | 1 | 1 = reused value, 0 = computed value |

## Verification
A corrupted reference entry in tracking mode shows up on the first window after the corruption. That window either hits when it should miss, returning the old value, or misses and returns a fresh kernel value with out_hit=0. The scoreboard compares both the flag and the data on every result, so the error is caught at that output. A stuck busy state shows as in_ready staying low beyond the kernel latency, and a hit that wrongly starts the kernel shows as in_ready dropping in the cycle after acceptance. Both are visible within one or two cycles of the window concerned.

// File: rtl/memo_pkg.sv
package memo_pkg;
    parameter int PIX_W = 8;
    parameter int NPIX  = 9;
    parameter int CTR   = 4;

    typedef struct packed {
        logic             busy;
        logic             ent_valid;
        logic [PIX_W-1:0] ent_pix;
        logic [PIX_W-1:0] ent_out;
        logic [PIX_W-1:0] pend_pix;
        logic             out_valid;
        logic [PIX_W-1:0] out_data;
        logic             out_hit;
    } memo_state_t;
endpackage

// File: rtl/memo_match.sv
module memo_match
    import memo_pkg::*;
(
    input  logic [PIX_W-1:0] probe,
    input  logic [PIX_W-1:0] refv,
    input  logic             use_dist,
    input  logic [PIX_W-1:0] thresh,
    output logic             match
);
    logic [PIX_W-1:0] diff;

    always_comb begin
        diff  = (probe >= refv) ? (probe - refv) : (refv - probe);
        match = use_dist ? (diff <= thresh) : (probe == refv);
    end
endmodule

// File: rtl/edge_kernel.sv
module edge_kernel
    import memo_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NPIX*PIX_W-1:0]  win,
    output logic                   done,
    output logic [PIX_W-1:0]       result
);
    localparam int SW = PIX_W + 4;
    localparam logic [SW-2:0] SAT = {{(SW-1-PIX_W){1'b0}}, {PIX_W{1'b1}}};

    logic signed [SW-1:0] px [NPIX];
    logic signed [SW-1:0] gx, gy;
    logic        [SW-2:0] ax, ay, mag;
    logic        [PIX_W-1:0] comb_res;

    always_comb begin
        for (int k = 0; k < NPIX; k++)
            px[k] = $signed({4'b0000, win[k*PIX_W +: PIX_W]});
        gx = (px[2] + 2*px[5] + px[8]) - (px[0] + 2*px[3] + px[6]);
        gy = (px[6] + 2*px[7] + px[8]) - (px[0] + 2*px[1] + px[2]);
        ax = gx[SW-1] ? SW'(-gx) : gx;
        ay = gy[SW-1] ? SW'(-gy) : gy;
        mag = ax + ay;
        comb_res = (mag > SAT) ? {PIX_W{1'b1}} : mag[PIX_W-1:0];
    end

    logic             vld_q [LATENCY];
    logic [PIX_W-1:0] dat_q [LATENCY];

    genvar s;
    generate
        for (s = 0; s < LATENCY; s++) begin : g_stage
            logic             vld_d;
            logic [PIX_W-1:0] dat_d;
            if (s == 0) begin : g_first
                always_comb begin
                    vld_d = start;
                    dat_d = comb_res;
                end
            end else begin : g_next
                always_comb begin
                    vld_d = vld_q[s-1];
                    dat_d = dat_q[s-1];
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    dat_q[s] <= '0;
                end else begin
                    vld_q[s] <= vld_d;
                    dat_q[s] <= dat_d;
                end
            end
        end
    endgenerate

    assign done   = vld_q[LATENCY-1];
    assign result = dat_q[LATENCY-1];
endmodule

// File: rtl/memo_wrap.sv
module memo_wrap
    import memo_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NPIX*PIX_W-1:0] in_win,
    input  logic                  cfg_dynamic,
    input  logic                  cfg_use_dist,
    input  logic [PIX_W-1:0]      cfg_thresh,
    input  logic [PIX_W-1:0]      cfg_ref_pix,
    input  logic [PIX_W-1:0]      cfg_ref_out,
    output logic                  out_valid,
    output logic [PIX_W-1:0]      out_data,
    output logic                  out_hit
);
    memo_state_t st_q, st_d;

    logic [PIX_W-1:0] centre, ref_pix, reuse_val;
    logic             sim, hit, accept, kern_start, kern_done;
    logic [PIX_W-1:0] kern_res;

    assign centre    = in_win[CTR*PIX_W +: PIX_W];
    assign ref_pix   = cfg_dynamic ? st_q.ent_pix : cfg_ref_pix;
    assign reuse_val = cfg_dynamic ? st_q.ent_out : cfg_ref_out;
    assign in_ready  = !st_q.busy;

    memo_match u_match (
        .probe    (centre),
        .refv     (ref_pix),
        .use_dist (cfg_use_dist),
        .thresh   (cfg_thresh),
        .match    (sim)
    );

    edge_kernel #(.LATENCY(LATENCY)) u_kernel (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (kern_start),
        .win    (in_win),
        .done   (kern_done),
        .result (kern_res)
    );

    always_comb begin
        hit        = sim && (!cfg_dynamic || st_q.ent_valid);
        accept     = in_valid && !st_q.busy;
        kern_start = accept && !hit;

        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.out_hit   = 1'b0;

        if (accept && hit) begin
            st_d.out_valid = 1'b1;
            st_d.out_hit   = 1'b1;
            st_d.out_data  = reuse_val;
        end
        if (kern_start) begin
            st_d.busy     = 1'b1;
            st_d.pend_pix = centre;
        end
        if (kern_done) begin
            st_d.busy      = 1'b0;
            st_d.out_valid = 1'b1;
            st_d.out_hit   = 1'b0;
            st_d.out_data  = kern_res;
            st_d.ent_valid = 1'b1;
            st_d.ent_pix   = st_q.pend_pix;
            st_d.ent_out   = kern_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
    assign out_hit   = st_q.out_hit;
endmodule

// File: rtl/memo_wrap_chk.sv
module memo_wrap_chk
    import memo_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             cfg_dynamic,
    input logic [PIX_W-1:0] cfg_ref_out,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_data,
    input logic             out_hit,
    input logic             kern_start,
    input logic             kern_done
);
    localparam int CW = $clog2(LATENCY + 2) + 1;
    logic [CW-1:0] stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stall_q <= '0;
        else if (in_ready) stall_q <= '0;
        else               stall_q <= stall_q + 1'b1;
    end

    a_r8_hit_skips_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> $past(!kern_start));

    a_r9_miss_from_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> $past(kern_done));

    a_r9_start_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        kern_start |=> !in_ready);

    a_r9_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (stall_q < CW'(LATENCY)));

    a_r3_static_value: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit && !cfg_dynamic) |-> (out_data == cfg_ref_out));
endmodule

bind memo_wrap memo_wrap_chk #(.LATENCY(LATENCY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .cfg_dynamic (cfg_dynamic),
    .cfg_ref_out (cfg_ref_out),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_hit     (out_hit),
    .kern_start  (kern_start),
    .kern_done   (kern_done)
);

// File: tb/tb_memo_wrap.sv
module tb_memo_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [71:0] in_win = '0;
    logic        cfg_dynamic = 1'b0, cfg_use_dist = 1'b0;
    logic [7:0]  cfg_thresh = '0, cfg_ref_pix = '0, cfg_ref_out = '0;
    logic        out_valid, out_hit;
    logic [7:0]  out_data;

    int n_run = 0, n_fail = 0;
    logic [8:0] exp_q [$];
    string      tag_q [$];
    bit         m_valid;
    logic [7:0] m_pix, m_out;

    always #10 clk = ~clk;

    memo_wrap dut (.*);

    function automatic logic [7:0] sobel(logic [71:0] w);
        int p [9];
        int gx, gy, m;
        for (int k = 0; k < 9; k++) p[k] = int'(w[8*k +: 8]);
        gx = (p[2] + 2*p[5] + p[8]) - (p[0] + 2*p[3] + p[6]);
        gy = (p[6] + 2*p[7] + p[8]) - (p[0] + 2*p[1] + p[2]);
        m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (m > 255) ? 8'd255 : m[7:0];
    endfunction

    function automatic logic [71:0] mkwin(logic [7:0] c, logic [7:0] a, logic [7:0] b);
        logic [71:0] w;
        for (int k = 0; k < 9; k++) w[8*k +: 8] = (k % 3 == 0) ? a : b;
        w[32 +: 8] = c;
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        m_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(logic [71:0] w, string req);
        logic [7:0] c, rp, ro, ad;
        bit sim, hit;
        logic [7:0] val;
        c  = w[32 +: 8];
        rp = cfg_dynamic ? m_pix : cfg_ref_pix;
        ro = cfg_dynamic ? m_out : cfg_ref_out;
        ad = (c >= rp) ? c - rp : rp - c;
        sim = cfg_use_dist ? (ad <= cfg_thresh) : (c == rp);
        hit = sim && (!cfg_dynamic || m_valid);
        val = hit ? ro : sobel(w);
        if (!hit) begin
            m_valid = 1'b1;
            m_pix = c;
            m_out = val;
        end
        exp_q.push_back({hit, val});
        tag_q.push_back(req);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_win = w;
        @(negedge clk);
        in_valid = 1'b0;
        if (hit) begin
            check({req, " R8 hit next cycle"}, {31'd0, out_valid}, 32'd1);
            check({req, " R8 ready kept"}, {31'd0, in_ready}, 32'd1);
        end else begin
            check({req, " R9 ready low"}, {31'd0, in_ready}, 32'd0);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected result", 32'd1, 32'd0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " flag/data"}, {23'd0, out_hit, out_data}, {23'd0, e});
            end
        end
    end

    task automatic drain();
        int k;
        for (k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
        check("R10 drain", exp_q.size(), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);

        // fixed mode, equality; thresh large but ignored (R4)
        cfg_dynamic = 0; cfg_use_dist = 0; cfg_thresh = 8'd255;
        cfg_ref_pix = 8'd100; cfg_ref_out = 8'd77;
        send(mkwin(8'd100, 8'd0, 8'd200), "R3 fixed hit first");
        send(mkwin(8'd101, 8'd10, 8'd20), "R4 eq near miss");
        send(mkwin(8'd50, 8'd3, 8'd3), "R4 eq far miss");
        send(mkwin(8'd100, 8'd9, 8'd1), "R3 fixed hit again");
        send(mkwin(8'd0, 8'd255, 8'd0), "R2 saturate");
        send(mkwin(8'd7, 8'd7, 8'd7), "R2 flat");
        drain();

        // fixed mode, distance
        cfg_use_dist = 1; cfg_thresh = 8'd3;
        send(mkwin(8'd103, 8'd1, 8'd2), "R5 edge inside");
        send(mkwin(8'd97, 8'd1, 8'd2), "R5 edge below");
        send(mkwin(8'd104, 8'd1, 8'd2), "R5 just outside");
        send(mkwin(8'd96, 8'd40, 8'd2), "R5 below outside");
        drain();

        // tracking mode, equality
        cfg_dynamic = 1; cfg_use_dist = 0;
        do_reset();
        send(mkwin(8'd100, 8'd10, 8'd60), "R7 first after reset");
        send(mkwin(8'd100, 8'd90, 8'd0), "R6 reuse last");
        send(mkwin(8'd20, 8'd5, 8'd50), "R6 new miss");
        send(mkwin(8'd100, 8'd5, 8'd50), "R6 old ref replaced");
        send(mkwin(8'd100, 8'd0, 8'd0), "R6 hit new entry");
        drain();

        // tracking mode, distance
        cfg_use_dist = 1; cfg_thresh = 8'd10;
        send(mkwin(8'd110, 8'd1, 8'd99), "R5 track inside");
        send(mkwin(8'd111, 8'd1, 8'd99), "R5 track outside");
        send(mkwin(8'd101, 8'd30, 8'd0), "R6 track reuse");
        cfg_thresh = 8'd0;
        send(mkwin(8'd111, 8'd30, 8'd0), "R5 zero thresh exact");
        drain();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule